// File: doc/BRIEF.md
# Nine-Bit-Group Serial Panel Command Transmitter

This block sends display-controller commands to a panel over a three-wire serial link: a serial clock, an active-low chip select that frames each command, and a data line. A host hands over one 32-bit command word at a time through a valid/ready handshake. The top two bits of the word give how many parameter bytes follow the command byte. The low 30 bits hold the payload, packed as groups of nine bits. In each group a leading flag bit marks command or data, and eight data bits follow it. One command becomes a single frame of 9, 18 or 27 bits, shifted out most significant bit first.

The serial clock comes from a divider of the system clock. Its half-period is taken from an input each time a command is accepted. The data line changes only when the serial clock falls, so the panel samples it on the rising edge. When a command's parameter count differs from that of the previous command, the block first spends a fixed reconfiguration interval retuning its frame length. A command with the same count starts at once. After each frame the chip select stays high for at least one serial-clock period before the block can take the next word. It signals completion with a one-cycle done pulse.

Top module: `panel_cmd_tx`

## Requirements
- R1: `in_ready` is high when the block is idle. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. From that edge until the done pulse, `in_ready` is low and `busy` is high.
- R2: Bits 31:30 of the word give the parameter count: 0, 1 or 2, with the value 3 treated as 2. These two bits are never transmitted.
- R3: With a count of 0, the frame is exactly 9 bits: word bits 8 down to 0, sent most significant first. Bit 8 is the command/data flag of the command group.
- R4: With a count of 1, the frame is exactly 18 bits: word bits 17 down to 0, sent most significant first. The command byte is in bits 16:9 and parameter 1 is in bits 7:0.
- R5: With a count of 2, the frame is exactly 27 bits: word bits 26 down to 0, sent most significant first. The command byte is in bits 25:18, parameter 1 in bits 16:9 and parameter 2 in bits 7:0.
- R6: `ser_clk` is low when the chip select falls. Each bit takes one low phase followed by one high phase. `ser_dat` changes only in the cycle where `ser_clk` falls, and the rising edge is where it is sampled.
- R7: Every low and high phase of `ser_clk` in a frame lasts H system clocks. H is the value of `sclk_half` sampled at acceptance, with 0 treated as 1.
- R8: `ser_cs_n` is low for the whole frame and only while `busy` is high. Between frames it stays high for at least 2·H system clocks.
- R9: A command is the first after reset, or its parameter count differs from that of the previous accepted command. Then `ser_cs_n` falls RECFG_CYC cycles after the acceptance edge. Otherwise it falls right after the acceptance edge.
- R10: `done` is a one-cycle pulse, raised once per command after the inter-frame gap. `in_ready` is high in the same cycle.
- R11: While `ser_cs_n` is high, `ser_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 32 | Count in 31:30, packed 9-bit groups below |
| sclk_half | input | DIV_W | Serial clock half-period in system clocks (0 means 1) |
| ser_clk | output | 1 | Serial clock to the panel |
| ser_cs_n | output | 1 | Active-low frame/chip select |
| ser_dat | output | 1 | Serial data, MSB first |
| busy | output | 1 | A command is being handled |
| done | output | 1 | One-cycle pulse at command completion |

## Verification
The assertions watch on every cycle that the handshake and busy agree, that data holds steady except on a falling serial clock, and that the serial clock idles low outside a frame. They also check that chip select is only active while busy and that done is a single pulse coincident with ready. Only the bench scenarios can show that the right bits go out in the right count for each parameter count, and that every clock phase has the programmed length. The same holds for the reconfiguration delay, which appears only when the count changes, and for the length of the inter-frame gap. These scenarios include a count field of 3 and a zero divider setting.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;

  localparam int CMD_W     = 32;
  localparam int GRP_W     = 9;
  localparam int MAX_GRP   = 3;
  localparam int FRAME_W   = GRP_W * MAX_GRP;
  localparam int PAYLOAD_W = CMD_W - 2;
  localparam int LEN_W     = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECFG,
    ST_SHIFT,
    ST_GAP
  } tx_state_e;

  // count field value 3 behaves as 2
  function automatic logic [1:0] sat_count(input logic [1:0] raw);
    return (raw == 2'd3) ? 2'd2 : raw;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic [1:0] cnt);
    logic [LEN_W-1:0] len;
    case (cnt)
      2'd0:    len = LEN_W'(GRP_W);
      2'd1:    len = LEN_W'(2 * GRP_W);
      default: len = LEN_W'(3 * GRP_W);
    endcase
    return len;
  endfunction

  // place the first transmitted bit at the top of the shift register
  function automatic logic [FRAME_W-1:0] align_frame(input logic [PAYLOAD_W-1:0] p,
                                                     input logic [1:0] cnt);
    logic [FRAME_W-1:0] f;
    case (cnt)
      2'd0:    f = {p[GRP_W-1:0], {(2*GRP_W){1'b0}}};
      2'd1:    f = {p[2*GRP_W-1:0], {GRP_W{1'b0}}};
      default: f = p[FRAME_W-1:0];
    endcase
    return f;
  endfunction

endpackage

// File: rtl/panel_cmd_tx_tick.sv
module panel_cmd_tx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == half_len - DIV_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/panel_cmd_tx_shift.sv
module panel_cmd_tx_shift
  import panel_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               active,
  input  logic               tick,
  output logic               ser_clk,
  output logic               ser_dat,
  output logic               frame_end
);

  logic [FRAME_W-1:0] sh;
  logic [LEN_W-1:0]   bit_idx;
  logic [LEN_W-1:0]   len_q;
  logic               sclk_q;
  logic               last_bit;

  assign last_bit  = (bit_idx == len_q - LEN_W'(1));
  assign frame_end = active && tick && sclk_q && last_bit;
  assign ser_clk   = sclk_q;
  assign ser_dat   = sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      bit_idx <= '0;
      len_q   <= LEN_W'(GRP_W);
      sclk_q  <= 1'b0;
    end else if (load) begin
      sh      <= frame_in;
      len_q   <= len_in;
      bit_idx <= '0;
      sclk_q  <= 1'b0;
    end else if (active && tick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        sclk_q <= 1'b0;
        if (last_bit) begin
          sh <= '0;
        end else begin
          sh      <= {sh[FRAME_W-2:0], 1'b0};
          bit_idx <= bit_idx + LEN_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/panel_cmd_tx_ctrl.sv
module panel_cmd_tx_ctrl
  import panel_cmd_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int RECFG_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       cnt_in,
  input  logic [DIV_W-1:0] sclk_half,
  input  logic             frame_end,
  input  logic             tick,
  output logic             in_ready,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  output logic             load,
  output logic             shifting,
  output logic             run,
  output logic [DIV_W-1:0] half_len
);

  localparam int RC_W = (RECFG_CYC > 1) ? $clog2(RECFG_CYC) : 1;

  tx_state_e       state;
  logic [1:0]      last_cnt;
  logic [RC_W-1:0] rc;
  logic            gap_half;
  logic            ready_q;

  assign in_ready = ready_q;
  assign load     = in_valid && ready_q;
  assign shifting = (state == ST_SHIFT);
  assign run      = (state == ST_SHIFT) || (state == ST_GAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ready_q  <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      cs_n     <= 1'b1;
      last_cnt <= 2'd3;
      rc       <= '0;
      gap_half <= 1'b0;
      half_len <= DIV_W'(1);
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid && ready_q) begin
            ready_q  <= 1'b0;
            busy     <= 1'b1;
            half_len <= (sclk_half == '0) ? DIV_W'(1) : sclk_half;
            last_cnt <= cnt_in;
            if (cnt_in != last_cnt) begin
              rc    <= RC_W'(RECFG_CYC - 1);
              state <= ST_RECFG;
            end else begin
              cs_n  <= 1'b0;
              state <= ST_SHIFT;
            end
          end
        end
        ST_RECFG: begin
          if (rc == '0) begin
            cs_n  <= 1'b0;
            state <= ST_SHIFT;
          end else begin
            rc <= rc - RC_W'(1);
          end
        end
        ST_SHIFT: begin
          if (frame_end) begin
            cs_n     <= 1'b1;
            gap_half <= 1'b0;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) begin
              state   <= ST_IDLE;
              ready_q <= 1'b1;
              busy    <= 1'b0;
              done    <= 1'b1;
            end else begin
              gap_half <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/panel_cmd_tx.sv
module panel_cmd_tx
  import panel_cmd_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int RECFG_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_word,
  input  logic [DIV_W-1:0] sclk_half,
  output logic             ser_clk,
  output logic             ser_cs_n,
  output logic             ser_dat,
  output logic             busy,
  output logic             done
);

  logic [1:0]         eff_cnt;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               load;
  logic               shifting;
  logic               run;
  logic               tick;
  logic               frame_end;
  logic [DIV_W-1:0]   half_len;

  // count field is dropped here; only the payload reaches the shifter
  assign eff_cnt = sat_count(in_word[CMD_W-1:CMD_W-2]);
  assign frame   = align_frame(in_word[PAYLOAD_W-1:0], eff_cnt);
  assign len     = frame_len(eff_cnt);

  panel_cmd_tx_ctrl #(
    .DIV_W    (DIV_W),
    .RECFG_CYC(RECFG_CYC)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .cnt_in   (eff_cnt),
    .sclk_half(sclk_half),
    .frame_end(frame_end),
    .tick     (tick),
    .in_ready (in_ready),
    .busy     (busy),
    .done     (done),
    .cs_n     (ser_cs_n),
    .load     (load),
    .shifting (shifting),
    .run      (run),
    .half_len (half_len)
  );

  panel_cmd_tx_tick #(
    .DIV_W(DIV_W)
  ) tick_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .half_len(half_len),
    .tick    (tick)
  );

  panel_cmd_tx_shift shift_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .frame_in (frame),
    .len_in   (len),
    .active   (shifting),
    .tick     (tick),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .frame_end(frame_end)
  );

endmodule

// File: rtl/panel_cmd_tx_chk.sv
module panel_cmd_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_cs_n,
  input logic ser_dat
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready); // R1

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready && busy)); // R1

  AST_DAT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!ser_cs_n && $past(!ser_cs_n) && !$fell(ser_clk)) |-> $stable(ser_dat)); // R6

  AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
    !ser_cs_n |-> busy); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready); // R10

  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    ser_cs_n |-> !ser_clk); // R11

endmodule

bind panel_cmd_tx panel_cmd_tx_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .busy    (busy),
  .done    (done),
  .ser_clk (ser_clk),
  .ser_cs_n(ser_cs_n),
  .ser_dat (ser_dat)
);

// File: tb/panel_cmd_tx_tb_top.sv
module panel_cmd_tx_tb_top;

  localparam int DIV_W     = 8;
  localparam int RECFG_CYC = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [31:0]      in_word = '0;
  logic [DIV_W-1:0] sclk_half = DIV_W'(1);
  logic             ser_clk, ser_cs_n, ser_dat, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int    exp_len, exp_lat, cur_h, prev_n, acc_cyc, done_cnt;
  int    exp_bits;
  string exp_tag;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  panel_cmd_tx #(.DIV_W(DIV_W), .RECFG_CYC(RECFG_CYC)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .sclk_half(sclk_half), .ser_clk(ser_clk),
    .ser_cs_n(ser_cs_n), .ser_dat(ser_dat), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int count_of(input logic [31:0] w);
    return (w[31:30] == 2'd3) ? 2 : int'(w[31:30]);
  endfunction

  function automatic int bits_of(input logic [31:0] w);
    int len = 9 * (count_of(w) + 1);
    return int'(w & ((32'd1 << len) - 32'd1));
  endfunction

  // frame monitor
  bit prev_cs = 1'b1, prev_clk = 1'b0, seen_frame = 1'b0;
  int ph_len = 0, nbits = 0, cap = 0, hi_cnt = 0, gap_h = 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        done_cnt++;
        chk(in_ready, "R10", "ready with done", int'(in_ready), 1);
      end
      if (!ser_cs_n) begin
        if (prev_cs) begin
          chk(cyc - acc_cyc == exp_lat, "R9", "start latency", cyc - acc_cyc, exp_lat);
          chk(!ser_clk, "R6", "clk low at frame start", int'(ser_clk), 0);
          if (seen_frame)
            chk(hi_cnt >= 2 * gap_h, "R8", "gap cycles", hi_cnt, 2 * gap_h);
          cap = 0; nbits = 0; ph_len = 1;
        end else if (ser_clk == prev_clk) begin
          ph_len++;
        end else begin
          chk(ph_len == cur_h, "R7", "phase length", ph_len, cur_h);
          ph_len = 1;
          if (ser_clk) begin
            cap = (cap << 1) | int'(ser_dat);
            nbits++;
          end
        end
      end else begin
        chk(!ser_clk, "R11", "clk idle low", int'(ser_clk), 0);
        if (!prev_cs) begin
          chk(ph_len == cur_h, "R7", "last phase length", ph_len, cur_h);
          chk(nbits == exp_len, exp_tag, "frame bit count", nbits, exp_len);
          chk(cap == exp_bits, exp_tag, "frame bits", cap, exp_bits);
          seen_frame = 1'b1; hi_cnt = 1; gap_h = cur_h;
        end else begin
          hi_cnt++;
        end
      end
      prev_cs  = ser_cs_n;
      prev_clk = ser_clk;
    end
  end

  task automatic send(input logic [31:0] w, input int half);
    int n = count_of(w);
    int target = done_cnt + 1;
    exp_len  = 9 * (n + 1);
    exp_bits = bits_of(w);
    exp_tag  = (w[31:30] == 2'd3) ? "R2" : (n == 0) ? "R3" : (n == 1) ? "R4" : "R5";
    cur_h    = (half == 0) ? 1 : half;
    exp_lat  = (n != prev_n) ? RECFG_CYC : 0;
    prev_n   = n;
    @(negedge clk);
    in_word   = w;
    sclk_half = DIV_W'(half);
    in_valid  = 1'b1;
    while (!in_ready) @(negedge clk);
    acc_cyc = cyc + 1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy && !in_ready, "R1", "busy after accept", int'(busy), 1);
    while (done_cnt < target) @(negedge clk);
    chk(done_cnt == target, "R10", "done pulses", done_cnt, target);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    prev_n = -1; done_cnt = 0; acc_cyc = 0;
    exp_len = 9; exp_lat = 0; cur_h = 1; exp_bits = 0; exp_tag = "R3";
    repeat (4) @(negedge clk);
    chk(in_ready, "R1", "reset ready", int'(in_ready), 1);
    chk(!busy, "R1", "reset busy", int'(busy), 0);
    chk(ser_cs_n, "R8", "reset cs_n", int'(ser_cs_n), 1);
    chk(!ser_clk, "R11", "reset ser_clk", int'(ser_clk), 0);
    rst = 1'b0;
    // directed: each count, repeats, count 3, divider zero
    send({2'd0, 21'h1ABCD, 9'h029}, 2);          // R3, first: reconfig delay R9
    send({2'd0, 21'h00000, 9'h011}, 2);          // R3 same count: no delay
    send({2'd1, 12'hFFF, 9'h0B0, 9'h116}, 1);    // R4
    send({2'd1, 12'h000, 9'h0B8, 9'h1FF}, 3);    // R4 same
    send({2'd2, 3'b111, 9'h0B8, 9'h1FF, 9'h1F9}, 0); // R5 with divider 0 (R7)
    send({2'd3, 3'b101, 9'h0C3, 9'h120, 9'h140}, 2); // R2 count 3 acts as 2
    send({2'd0, 21'h1FFFF, 9'h1FF}, 4);          // R3 all ones
    for (int i = 0; i < 40; i++) begin
      send($urandom, int'($urandom_range(0, 4)));
    end
    repeat (10) @(negedge clk);
    chk(in_ready && ser_cs_n, "R1", "final idle", int'(in_ready), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule